// File: doc/BRIEF.md
# State Occupancy Profiler

This block measures where a monitored state machine spends its time. Each clock cycle, the machine's encoded current state selects one counter, and that counter advances by one. A machine holds exactly one state per cycle, so at most one counter changes in any cycle. The design relies on this to keep the counters in synchronous RAM instead of flip-flops. Each update is a two-stage read-modify-write. When the same state appears in back-to-back cycles, a one-entry forwarding path supplies the value that is still being written.

A free-running cycle counter advances alongside the per-state counters, so each state's count can be expressed as a share of total runtime. A control input stops counting without losing data. A clear request zeroes every counter and the cycle count by walking the RAM one address per cycle. A read port returns one counter per request. It can be used after the run, or while counting continues, with a bounded lag.

Top module: `state_occupancy_prof`

## Requirements
- R1: After reset is released, `busy` stays high for exactly NUM_STATES cycles. Afterwards every counter reads zero and `cyc_count` is zero.
- R2: In each cycle where `run_en`=1, `mon_valid`=1, `busy`=0 and `mon_state` < NUM_STATES, the counter indexed by `mon_state` grows by one. This holds when the same state repeats on consecutive cycles.
- R3: No counter changes for a cycle where `run_en`=0, `mon_valid`=0 or `mon_state` >= NUM_STATES. While `run_en`=0, `cyc_count` holds its value.
- R4: `cyc_count` grows by one after each cycle with `run_en`=1 and `busy`=0, and stops at 2^CYC_W-1.
- R5: A state counter stops at 2^CNT_W-1 and never wraps to zero.
- R6: A `clr_req` pulse while `busy`=0 raises `busy` from the next cycle for exactly NUM_STATES cycles and zeroes all counters and `cyc_count`. Events in the request cycle and during `busy` are dropped, and `clr_req` while `busy`=1 has no effect.
- R7: `rd_req` with `rd_addr` in cycle k gives `rd_valid`=1 and the counter in `rd_data` in cycle k+1. An `rd_addr` >= NUM_STATES returns zero.
- R8: A read requested in cycle k while counting continues includes every event accepted up to cycle k-2. It excludes the events of cycles k-1 and k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_state | input | STATE_W | Encoded current state of the watched machine |
| mon_valid | input | 1 | `mon_state` is meaningful this cycle |
| run_en | input | 1 | Counting enabled; low stops the profiler |
| clr_req | input | 1 | Start the zeroing walk |
| rd_req | input | 1 | Read one counter |
| rd_addr | input | STATE_W | Counter index to read |
| rd_valid | output | 1 | `rd_data` holds the requested counter |
| rd_data | output | CNT_W | Counter value |
| busy | output | 1 | Zeroing walk in progress |
| cyc_count | output | CYC_W | Enabled-cycle count |

## Verification
The bench builds the block with NUM_STATES=6, CNT_W=4 and CYC_W=8. Six states on a 3-bit index leave codes 6 and 7 unused, which exercises the out-of-range filtering on both the count path and the read path. A 4-bit counter saturates after 15 hits, and the 8-bit cycle count saturates after 255 cycles, so both ceilings are reached in a few hundred cycles. The bench also issues a read in the middle of a run of identical states, which tests the forwarding path and the exact read lag together.

// File: rtl/prof_pkg.sv
package prof_pkg;
   typedef enum logic [1:0] {
      WSRC_IDLE  = 2'd0,
      WSRC_ZERO  = 2'd1,
      WSRC_BUMP  = 2'd2
   } wsrc_e;
endpackage

// File: rtl/prof_store.sv
module prof_store #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32,
   parameter int AW    = 4,
   parameter int NRD   = 2
) (
   input  logic                 clk,
   input  logic                 we,
   input  logic [AW-1:0]        waddr,
   input  logic [WIDTH-1:0]     wdata,
   input  logic [NRD-1:0]       re,
   input  logic [NRD*AW-1:0]    raddr,
   output logic [NRD*WIDTH-1:0] rdata
);
   generate
      if (DEPTH > (1 << AW)) begin : g_bad_depth
         $error("prof_store: DEPTH exceeds address range");
      end
      // one bank per read port, all banks share the write
      for (genvar g = 0; g < NRD; g++) begin : g_bank
         logic [WIDTH-1:0] mem [DEPTH];
         logic [WIDTH-1:0] q;
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
            if (re[g]) q <= mem[raddr[g*AW +: AW]];
         end
         assign rdata[g*WIDTH +: WIDTH] = q;
      end
   endgenerate
endmodule

// File: rtl/prof_clear_seq.sv
module prof_clear_seq #(
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b1;
         addr <= '0;
      end else if (busy) begin
         if (addr == LAST) busy <= 1'b0;
         else              addr <= addr + 1'b1;
      end else if (start) begin
         busy <= 1'b1;
         addr <= '0;
      end
   end

   assert_walk_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (addr <= LAST));
   assert_walk_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(addr) == LAST));
endmodule

// File: rtl/prof_cyc_ctr.sv
module prof_cyc_ctr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)               count <= '0;
      else if (clr)             count <= '0;
      else if (en && !(&count)) count <= count + 1'b1;
   end

   assert_cyc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !en) |=> $stable(count));
   assert_cyc_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && en && (&count)) |=> (&count));
endmodule

// File: rtl/state_occupancy_prof.sv
module state_occupancy_prof
   import prof_pkg::*;
#(
   parameter int NUM_STATES = 16,
   parameter int CNT_W      = 32,
   parameter int CYC_W      = 32,
   localparam int STATE_W   = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STATE_W-1:0] mon_state,
   input  logic               mon_valid,
   input  logic               run_en,
   input  logic               clr_req,
   input  logic               rd_req,
   input  logic [STATE_W-1:0] rd_addr,
   output logic               rd_valid,
   output logic [CNT_W-1:0]   rd_data,
   output logic               busy,
   output logic [CYC_W-1:0]   cyc_count
);
   localparam bit FULL_MAP = (NUM_STATES == (1 << STATE_W));

   generate
      if (NUM_STATES < 2) begin : g_bad_states
         $error("state_occupancy_prof: NUM_STATES must be at least 2");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("state_occupancy_prof: CNT_W must be at least 2");
      end
      if (CYC_W < 1) begin : g_bad_cyc
         $error("state_occupancy_prof: CYC_W must be at least 1");
      end
   endgenerate

   function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
      return (&v) ? v : v + 1'b1;
   endfunction

   // index range filtering, only needed when codes are left unused
   logic st_ok, rd_ok;
   generate
      if (FULL_MAP) begin : g_full
         assign st_ok = 1'b1;
         assign rd_ok = 1'b1;
      end else begin : g_part
         localparam logic [STATE_W-1:0] LIM = STATE_W'(NUM_STATES);
         assign st_ok = (mon_state < LIM);
         assign rd_ok = (rd_addr < LIM);
      end
   endgenerate

   logic               clr_busy;
   logic [STATE_W-1:0] clr_addr;

   prof_clear_seq #(.DEPTH(NUM_STATES), .AW(STATE_W)) u_clr (
      .clk(clk), .rst_n(rst_n), .start(clr_req), .busy(clr_busy), .addr(clr_addr)
   );
   assign busy = clr_busy;

   // stage 0: accept an event and launch the lookup
   logic accept;
   assign accept = run_en && mon_valid && st_ok && !clr_busy && !clr_req;

   // stage 1: add one, forwarding the last write on a repeat
   logic               s1_vld;
   logic [STATE_W-1:0] s1_addr;
   logic               fw_vld;
   logic [STATE_W-1:0] fw_addr;
   logic [CNT_W-1:0]   fw_data;
   logic [CNT_W-1:0]   look_q, host_q, base, bump_data;
   logic               bump_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_addr <= '0;
         fw_vld  <= 1'b0;
         fw_addr <= '0;
         fw_data <= '0;
      end else begin
         s1_vld  <= accept;
         s1_addr <= mon_state;
         fw_vld  <= bump_we;
         fw_addr <= s1_addr;
         fw_data <= bump_data;
      end
   end

   assign base      = (fw_vld && (fw_addr == s1_addr)) ? fw_data : look_q;
   assign bump_data = sat_inc(base);
   assign bump_we   = s1_vld && !clr_busy;

   // write source selection: the zeroing walk wins
   wsrc_e              wsrc;
   logic               st_we;
   logic [STATE_W-1:0] st_waddr;
   logic [CNT_W-1:0]   st_wdata;

   always_comb begin
      if (clr_busy)     wsrc = WSRC_ZERO;
      else if (bump_we) wsrc = WSRC_BUMP;
      else              wsrc = WSRC_IDLE;
      st_we    = (wsrc != WSRC_IDLE);
      st_waddr = (wsrc == WSRC_ZERO) ? clr_addr : s1_addr;
      st_wdata = (wsrc == WSRC_ZERO) ? '0 : bump_data;
   end

   logic [STATE_W-1:0]   host_addr;
   logic [2*CNT_W-1:0]   rd_bus;
   assign host_addr = rd_ok ? rd_addr : '0;

   prof_store #(.DEPTH(NUM_STATES), .WIDTH(CNT_W), .AW(STATE_W), .NRD(2)) u_store (
      .clk   (clk),
      .we    (st_we),
      .waddr (st_waddr),
      .wdata (st_wdata),
      .re    ({rd_req, accept}),
      .raddr ({host_addr, mon_state}),
      .rdata (rd_bus)
   );
   assign look_q = rd_bus[0 +: CNT_W];
   assign host_q = rd_bus[CNT_W +: CNT_W];

   // host read response
   logic rd_oor;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_oor   <= 1'b0;
      end else begin
         rd_valid <= rd_req;
         rd_oor   <= !rd_ok;
      end
   end
   assign rd_data = rd_oor ? '0 : host_q;

   prof_cyc_ctr #(.W(CYC_W)) u_cyc (
      .clk(clk), .rst_n(rst_n), .clr(clr_busy), .en(run_en && !clr_busy), .count(cyc_count)
   );

   assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bump_we |-> (bump_data != '0));
   assert_stop_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !bump_we);
   assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);
   assert_walk_excludes_bump_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_busy |=> !s1_vld);
endmodule

// File: tb/sim_state_occupancy_prof.sv
module sim_state_occupancy_prof;
   localparam int N   = 6;
   localparam int CW  = 4;
   localparam int YW  = 8;
   localparam int SW  = 3;
   localparam int CMAX = (1 << CW) - 1;
   localparam int YMAX = (1 << YW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [SW-1:0] mon_state = '0;
   logic          mon_valid = 1'b0;
   logic          run_en = 1'b0;
   logic          clr_req = 1'b0;
   logic          rd_req = 1'b0;
   logic [SW-1:0] rd_addr = '0;
   logic          rd_valid;
   logic [CW-1:0] rd_data;
   logic          busy;
   logic [YW-1:0] cyc_count;

   int checks = 0;
   int fails = 0;
   int exp_cnt [N];
   int exp_cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   state_occupancy_prof #(.NUM_STATES(N), .CNT_W(CW), .CYC_W(YW)) u0 (
      .clk(clk), .rst_n(rst_n), .mon_state(mon_state), .mon_valid(mon_valid),
      .run_en(run_en), .clr_req(clr_req), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .cyc_count(cyc_count)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model(input int st, input bit v, input bit run);
      if (run && v && st < N && exp_cnt[st] < CMAX) exp_cnt[st]++;
      if (run && exp_cyc < YMAX) exp_cyc++;
   endtask

   task automatic model_clear();
      for (int i = 0; i < N; i++) exp_cnt[i] = 0;
      exp_cyc = 0;
   endtask

   task automatic cyc(input int st, input bit v, input bit run);
      @(negedge clk);
      mon_state = SW'(st); mon_valid = v; run_en = run; rd_req = 1'b0;
      model(st, v, run);
   endtask

   task automatic rd(input string req, input int a, input int exp);
      @(negedge clk);
      run_en = 1'b0; mon_valid = 1'b0; rd_req = 1'b1; rd_addr = SW'(a);
      @(negedge clk);
      chk({req, " rd_valid"}, int'(rd_valid), 1);
      chk(req, int'(rd_data), exp);
      rd_req = 1'b0;
   endtask

   task automatic check_all(input string req);
      for (int s = 0; s < N; s++) rd(req, s, exp_cnt[s]);
      chk({req, " cyc_count"}, int'(cyc_count), exp_cyc);
   endtask

   task automatic t_reset_R1();
      int n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      while (busy && n < 100) begin
         n++;
         @(negedge clk);
      end
      chk("R1 busy length", n, N);
      model_clear();
      check_all("R1 zero after reset");
   endtask

   task automatic t_basic_R2();
      int seq [12] = '{0, 0, 0, 1, 2, 1, 1, 3, 5, 5, 0, 4};
      for (int i = 0; i < 12; i++) cyc(seq[i], 1'b1, 1'b1);
      cyc(0, 1'b0, 1'b0);
      check_all("R2 repeats and alternation");
   endtask

   task automatic t_ignore_R3();
      cyc(1, 1'b0, 1'b1);
      cyc(6, 1'b1, 1'b1);
      cyc(7, 1'b1, 1'b1);
      cyc(2, 1'b1, 1'b0);
      cyc(2, 1'b1, 1'b0);
      cyc(3, 1'b0, 1'b1);
      cyc(0, 1'b0, 1'b0);
      check_all("R3 ignored cycles");
   endtask

   task automatic t_sat_R5();
      for (int i = 0; i < 20; i++) cyc(2, 1'b1, 1'b1);
      cyc(0, 1'b0, 1'b0);
      check_all("R5 counter ceiling");
   endtask

   task automatic t_cyc_sat_R4();
      for (int i = 0; i < 300; i++) cyc(0, 1'b0, 1'b1);
      cyc(0, 1'b0, 1'b0);
      chk("R4 cycle ceiling", int'(cyc_count), YMAX);
      check_all("R4 counters untouched");
   endtask

   task automatic t_clear_R6();
      @(negedge clk);
      clr_req = 1'b1; run_en = 1'b1; mon_valid = 1'b1; mon_state = 3'd1;
      for (int k = 1; k <= N; k++) begin
         @(negedge clk);
         chk("R6 busy during walk", int'(busy), 1);
         clr_req   = (k == 2);
         run_en    = (k < N);
         mon_valid = 1'b1;
         mon_state = SW'(k % N);
      end
      @(negedge clk);
      chk("R6 busy ends after NUM_STATES", int'(busy), 0);
      clr_req = 1'b0; run_en = 1'b0; mon_valid = 1'b0;
      model_clear();
      check_all("R6 all zero after clear");
   endtask

   task automatic t_sampled_R8();
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         if (i == 7) begin
            chk("R8 sampled rd_valid", int'(rd_valid), 1);
            chk("R8 sampled lag", int'(rd_data), 4);
         end
         mon_state = 3'd4; mon_valid = 1'b1; run_en = 1'b1;
         rd_req = (i == 6); rd_addr = 3'd4;
         model(4, 1'b1, 1'b1);
      end
      cyc(0, 1'b0, 1'b0);
      check_all("R8 final after sampled run");
   endtask

   task automatic t_oor_R7();
      rd("R7 unused index 6", 6, 0);
      rd("R7 unused index 7", 7, 0);
      rd("R7 valid index 4", 4, exp_cnt[4]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      t_reset_R1();
      t_basic_R2();
      t_ignore_R3();
      t_sat_R5();
      t_cyc_sat_R4();
      t_clear_R6();
      t_sampled_R8();
      t_oor_R7();
      finish_run();
   end
endmodule